// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Writer

This block loads a value of up to eight bits into a bank of single-bit tuning cells inside one of several PHYs, using a single 16-bit control word as the only path to them. Each request names a first cell address, a data word, a bit count and a target PHY. The writer sends the data one bit at a time, starting with the least significant bit. The cell address goes up by one for each bit. Every bit gets its own address phase and its own strobe pulse on the strobe line that belongs to the chosen PHY.

Requests come in over a valid/ready handshake. `req_ready` is high only when no burst is running. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A request offered while `req_ready` is low is dropped, not queued, so the upstream side must keep `req_valid` high until it sees ready at an edge. A plain configuration pin chooses the newer-variant behaviour, which zeroes the whole control word once before the first bit. For self-checking, the block contains a target model: each PHY has 256 one-bit cells, which can be read back by PHY and address.

Typical writes include a five-bit amplitude code 0x14 at cell 0x20, a two-bit threshold at 0x2a, a one-bit calibration enable at 0x0c on PHY 0, and a two-bit squelch field at 0x3c (value 0 enables, value 2 disables).

Top module: `ptune_writer`

## Requirements
- R1: After reset, `ctl_word` is 0, `busy` and `done` are low, `req_ready` is high, and every target cell reads 0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` equals the inverse of `busy`, and a request offered while busy has no effect on `ctl_word` or on the cells.
- R3: In `ctl_word`, bits 15:8 hold the cell address, bit 7 holds the serial data bit, and bit 2*n is the strobe for PHY n (n = 0..3). Bits 1, 3 and 5 always stay 0.
- R4: Bit i of the burst carries data bit i, with bit 0 sent first. It goes to address (start + i) modulo 256.
- R5: Each bit takes four cycles, one per phase, in this order: the address is written; the data bit is written with the strobe low; the strobe goes high; the strobe goes low. `busy` goes high in the cycle after the request is taken and goes low in the same edge that lowers the last strobe.
- R6: Only the strobe of the selected PHY ever goes high, and at most one strobe is high at any time.
- R7: When `cfg_clear_first` is 1 at the edge where a request is taken, the burst starts with one extra cycle in which the whole control word is written to 0. This happens before the first address phase.
- R8: `done` is high for exactly one cycle, in the cycle right after `busy` falls, and never while `busy` is high.
- R9: A bit count of 0 is taken as a no-op. `busy` stays low, `ctl_word` does not change (no clear even with `cfg_clear_first` set), and `done` is high for one cycle in the cycle after the request is taken.
- R10: A bit count above 8 is handled as 8.
- R11: A cell of PHY n takes the data bit at the address in `ctl_word` on a rising edge of strobe n. `rd_bit` shows the cell chosen by `rd_phy` and `rd_addr` through combinational logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is being offered |
| req_ready | output | 1 | The writer is idle and will take a request |
| req_addr | input | 8 | Address of the first cell |
| req_data | input | 8 | Data word, sent LSB first |
| req_len | input | 4 | Bit count, 0 = no-op, above 8 treated as 8 |
| req_phy | input | 2 | Index of the target PHY |
| cfg_clear_first | input | 1 | Zero the control word before each burst |
| busy | output | 1 | A burst is running |
| done | output | 1 | One-cycle pulse when a request has finished |
| ctl_word | output | 16 | Control word seen by the PHYs |
| rd_phy | input | 2 | Readback PHY select |
| rd_addr | input | 8 | Readback cell address |
| rd_bit | output | 1 | Readback cell value |

## Verification
The hardest cases to reach from the ports are the ones where requests collide with the writer's own timing. The first is a request offered while a burst is running. The second is a request offered on the very edge where the last strobe falls, when `busy` is still high. To reach both, the bench keeps `req_valid` high with a conflicting request on every cycle of every burst. It lowers `req_valid` only after it has seen `busy` go low. It then compares the control word, cycle by cycle, against a sequence built arithmetically. The bench also sweeps every PHY, every bit count from 0 to 10 and both clear modes. It uses start addresses that wrap past 255. After each burst it compares all four cell banks against a shadow model.

// File: rtl/ptune_pkg.sv
package ptune_pkg;
  localparam int DBIT_POS = 7;
  localparam int LOW_W    = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLR,
    PH_ADDR,
    PH_DATA,
    PH_STRH,
    PH_STRL
  } phase_e;
endpackage

// File: rtl/ptune_seq.sv
module ptune_seq
  import ptune_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int MAX_BITS = 8,
  parameter int PHY_W    = 2,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [MAX_BITS-1:0] st_data,
  input  logic [CNT_W-1:0]  st_cnt,
  input  logic [PHY_W-1:0]  st_phy,
  input  logic              st_clr,
  output phase_e            phase,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_bit,
  output logic [PHY_W-1:0]  cur_phy,
  output logic              busy,
  output logic              done
);
  logic [ADDR_W-1:0]   addr_q;
  logic [MAX_BITS-1:0] shift_q;
  logic [CNT_W-1:0]    left_q;
  logic [PHY_W-1:0]    phy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      addr_q  <= '0;
      shift_q <= '0;
      left_q  <= '0;
      phy_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            if (st_cnt == '0) begin
              done <= 1'b1;
            end else begin
              addr_q  <= st_addr;
              shift_q <= st_data;
              left_q  <= st_cnt;
              phy_q   <= st_phy;
              phase   <= st_clr ? PH_CLR : PH_ADDR;
            end
          end
        end
        PH_CLR:  phase <= PH_ADDR;
        PH_ADDR: phase <= PH_DATA;
        PH_DATA: phase <= PH_STRH;
        PH_STRH: phase <= PH_STRL;
        PH_STRL: begin
          if (left_q == CNT_W'(1)) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            left_q  <= left_q - 1'b1;
            addr_q  <= addr_q + 1'b1;
            shift_q <= shift_q >> 1;
            phase   <= PH_ADDR;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cur_addr = addr_q;
  assign cur_bit  = shift_q[0];
  assign cur_phy  = phy_q;
  assign busy     = (phase != PH_IDLE);
endmodule

// File: rtl/ptune_ctl_reg.sv
module ptune_ctl_reg
  import ptune_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_PHY = 4,
  parameter int PHY_W   = 2,
  parameter int CTL_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cur_bit,
  input  logic [PHY_W-1:0]  cur_phy,
  output logic [CTL_W-1:0]  ctl_q
);
  logic [CTL_W-1:0] nxt;

  always_comb begin
    nxt = ctl_q;
    case (phase)
      PH_CLR:  nxt = '0;
      PH_ADDR: nxt[CTL_W-1 -: ADDR_W] = cur_addr;
      PH_DATA: begin
        nxt[DBIT_POS] = cur_bit;
        for (int n = 0; n < NUM_PHY; n++)
          if (PHY_W'(n) == cur_phy) nxt[2*n] = 1'b0;
      end
      PH_STRH: begin
        for (int n = 0; n < NUM_PHY; n++)
          if (PHY_W'(n) == cur_phy) nxt[2*n] = 1'b1;
      end
      PH_STRL: begin
        for (int n = 0; n < NUM_PHY; n++)
          if (PHY_W'(n) == cur_phy) nxt[2*n] = 1'b0;
      end
      default: nxt = ctl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= nxt;
  end
endmodule

// File: rtl/ptune_target_bank.sv
module ptune_target_bank #(
  parameter int ADDR_W  = 8,
  parameter int NUM_PHY = 4,
  parameter int PHY_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  t_addr,
  input  logic               t_bit,
  input  logic [NUM_PHY-1:0] t_strb,
  input  logic [PHY_W-1:0]   rd_phy,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [NUM_PHY-1:0] rd_bits;

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_phy
    logic [DEPTH-1:0] cells;
    logic             strb_d;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cells  <= '0;
        strb_d <= 1'b0;
      end else begin
        strb_d <= t_strb[g];
        if (t_strb[g] && !strb_d) cells[t_addr] <= t_bit;
      end
    end

    assign rd_bits[g] = cells[rd_addr];
  end

  assign rd_bit = rd_bits[rd_phy];
endmodule

// File: rtl/ptune_writer.sv
module ptune_writer
  import ptune_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int MAX_BITS = 8,
  parameter int NUM_PHY  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [MAX_BITS-1:0]           req_data,
  input  logic [$clog2(MAX_BITS+1)-1:0] req_len,
  input  logic [$clog2(NUM_PHY)-1:0]    req_phy,
  input  logic                          cfg_clear_first,
  output logic                          busy,
  output logic                          done,
  output logic [ADDR_W+LOW_W-1:0]       ctl_word,
  input  logic [$clog2(NUM_PHY)-1:0]    rd_phy,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic                          rd_bit
);
  localparam int CTL_W = ADDR_W + LOW_W;
  localparam int PHY_W = $clog2(NUM_PHY);
  localparam int CNT_W = $clog2(MAX_BITS + 1);

  phase_e             phase;
  logic [ADDR_W-1:0]  cur_addr;
  logic               cur_bit;
  logic [PHY_W-1:0]   cur_phy;
  logic [CNT_W-1:0]   eff_len;
  logic               take;
  logic [NUM_PHY-1:0] strb;

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;
  assign eff_len   = (req_len > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : req_len;

  ptune_seq #(
    .ADDR_W(ADDR_W), .MAX_BITS(MAX_BITS), .PHY_W(PHY_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(take),
    .st_addr(req_addr), .st_data(req_data), .st_cnt(eff_len),
    .st_phy(req_phy), .st_clr(cfg_clear_first),
    .phase(phase), .cur_addr(cur_addr), .cur_bit(cur_bit),
    .cur_phy(cur_phy), .busy(busy), .done(done)
  );

  ptune_ctl_reg #(
    .ADDR_W(ADDR_W), .NUM_PHY(NUM_PHY), .PHY_W(PHY_W), .CTL_W(CTL_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cur_addr(cur_addr),
    .cur_bit(cur_bit), .cur_phy(cur_phy), .ctl_q(ctl_word)
  );

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_strb
    assign strb[g] = ctl_word[2*g];
  end

  ptune_target_bank #(
    .ADDR_W(ADDR_W), .NUM_PHY(NUM_PHY), .PHY_W(PHY_W)
  ) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .t_addr(ctl_word[CTL_W-1 -: ADDR_W]), .t_bit(ctl_word[DBIT_POS]),
    .t_strb(strb), .rd_phy(rd_phy), .rd_addr(rd_addr), .rd_bit(rd_bit)
  );
endmodule

// File: rtl/ptune_writer_chk.sv
module ptune_writer_chk #(
  parameter int ADDR_W   = 8,
  parameter int MAX_BITS = 8,
  parameter int NUM_PHY  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [$clog2(MAX_BITS+1)-1:0] req_len,
  input logic                          cfg_clear_first,
  input logic                          busy,
  input logic                          done,
  input logic [ADDR_W+7:0]             ctl_word
);
  localparam int CTL_W = ADDR_W + 8;

  logic [NUM_PHY-1:0] strb;
  logic [CTL_W-1:0]   odd_mask;

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_s
    assign strb[g]         = ctl_word[2*g];
    assign odd_mask[2*g]   = 1'b0;
    assign odd_mask[2*g+1] = (2*g+1 != 7);
  end
  for (genvar h = 2*NUM_PHY; h < CTL_W; h++) begin : g_m
    assign odd_mask[h] = 1'b0;
  end

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));

  a_r3_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word & odd_mask) == '0);

  a_r2_busy_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  a_r5_strobe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb) |-> busy);

  a_r5_fields_hold_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb) |-> $stable(ctl_word[CTL_W-1:7]));

  a_r7_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(cfg_clear_first)) |=> (ctl_word == '0));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (done && !busy));
endmodule

bind ptune_writer ptune_writer_chk #(
  .ADDR_W(ADDR_W), .MAX_BITS(MAX_BITS), .NUM_PHY(NUM_PHY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .cfg_clear_first(cfg_clear_first), .busy(busy),
  .done(done), .ctl_word(ctl_word)
);

// File: tb/ptune_writer_test.sv
`timescale 1ns/1ps
module ptune_writer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic [3:0] req_len = '0;
  logic [1:0] req_phy = '0;
  logic       cfg_clear_first = 1'b0;
  logic       busy, done, rd_bit;
  logic [15:0] ctl_word;
  logic [1:0] rd_phy = '0;
  logic [7:0] rd_addr = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_ctl = '0;
  logic shadow [4][256];

  always #2 clk = ~clk;

  ptune_writer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
    .req_phy(req_phy), .cfg_clear_first(cfg_clear_first), .busy(busy),
    .done(done), .ctl_word(ctl_word), .rd_phy(rd_phy), .rd_addr(rd_addr),
    .rd_bit(rd_bit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_store(input string tag);
    int miss = 0;
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 256; k++) begin
        rd_phy = 2'(p);
        rd_addr = 8'(k);
        #1ps;
        if (rd_bit !== shadow[p][k]) miss++;
      end
    chk(tag, miss, 0);
  endtask

  task automatic burst(input int p, input int a, input int d, input int len, input bit clr);
    int n = (len > 8) ? 8 : len;
    @(negedge clk);
    req_valid = 1'b1; req_phy = 2'(p); req_addr = 8'(a);
    req_data = 8'(d); req_len = 4'(len); cfg_clear_first = clr;
    @(negedge clk);
    // conflicting request held while busy: must be ignored (R2)
    req_phy = 2'(p + 1); req_addr = 8'(a + 77); req_data = 8'(~d); req_len = 4'd3;
    if (n == 0) begin
      req_valid = 1'b0;
      chk("R9 busy", busy, 0);
      chk("R9 done", done, 1);
      chk("R9 ctl", ctl_word, exp_ctl);
      @(negedge clk);
      chk("R8 done width", done, 0);
      return;
    end
    chk("R2 ready", req_ready, 0);
    chk("R5 busy start", busy, 1);
    chk("R5 ctl hold", ctl_word, exp_ctl);
    if (clr) begin
      @(negedge clk);
      exp_ctl = '0;
      chk("R7 clear", ctl_word, exp_ctl);
    end
    for (int i = 0; i < n; i++) begin
      int ai = (a + i) & 255;
      int bi = (d >> i) & 1;
      @(negedge clk);
      exp_ctl[15:8] = 8'(ai);
      chk("R4 addr", ctl_word, exp_ctl);
      @(negedge clk);
      exp_ctl[7] = bi[0];
      exp_ctl[2*p] = 1'b0;
      chk("R3 data", ctl_word, exp_ctl);
      @(negedge clk);
      exp_ctl[2*p] = 1'b1;
      chk("R6 strobe high", ctl_word, exp_ctl);
      @(negedge clk);
      exp_ctl[2*p] = 1'b0;
      shadow[p][ai] = bi[0];
      chk("R5 strobe low", ctl_word, exp_ctl);
      if (i < n - 1) chk("R5 busy mid", busy, 1);
      else begin
        req_valid = 1'b0;
        chk(len > 8 ? "R10 busy end" : "R5 busy end", busy, 0);
        chk("R8 done", done, 1);
      end
    end
    @(negedge clk);
    chk("R8 done width", done, 0);
    chk("R2 ignored", ctl_word, exp_ctl);
    cmp_store(len > 8 ? "R10 store" : "R11 store");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 256; k++) shadow[p][k] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl", ctl_word, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ready", req_ready, 1);
    cmp_store("R1 store");

    burst(0, 8'h0c, 1, 1, 1'b0);
    burst(1, 8'h20, 8'h14, 5, 1'b0);
    burst(2, 8'h2a, 3, 2, 1'b1);
    burst(3, 8'h3c, 2, 2, 1'b0);
    burst(3, 8'h3c, 0, 2, 1'b1);
    burst(0, 8'hfe, 8'hb5, 8, 1'b0);
    burst(2, 8'h10, 8'hff, 0, 1'b1);

    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 4; p++)
        for (int len = 0; len <= 10; len++)
          burst(p, (p*67 + len*29 + c*113 + 200) & 255,
                (p*53 + len*97 + 8'h5a) & 255, len, c[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule